// File: doc/BRIEF.md
# Display Panel Bring-up Sequencer

This block takes a small TFT display controller from cold reset to an active display over a 4-wire serial link: an active-low chip-select, a serial clock, a serial data line and a data/command select line. A start request turns on the panel supply while the panel reset is held low. After a settling wait, reset is released. After a second wait, the block walks an internal table of controller commands. Each table entry holds an opcode, a parameter count and a flag that asks for a long pause once the frame has been sent.

All waits come from one millisecond timer. Its length is set by the `CLK_PER_MS` parameter, so a simulation can run with short waits and the same timing structure. Once the panel is running, a single-cycle request sends one display-on or one display-off frame, and a stop request powers the panel down. Requests are plain level-sampled control pins. The block has no data stream of its own, so it uses no valid/ready handshake at its edge.

Top module: `panel_bringup_seq`

## Requirements
- R1: While reset is applied and after it is released: `supply_en_o` is low, `panel_rst_n_o` is low (panel held in reset), `spi_cs_n_o` is high, `spi_sck_o` is low, and `busy_o` and `done_o` are low.
- R2: A `start_i` pulse while powered off raises `supply_en_o`. `panel_rst_n_o` rises between `RST_MS*CLK_PER_MS` and `RST_MS*CLK_PER_MS+2` cycles later. The first frame begins no sooner than `RST_MS*CLK_PER_MS` cycles after that rise.
- R3: The serial link uses mode 0. The clock idles low, each byte is sent most significant bit first, the data line changes only while the clock is low, and every high or low clock phase inside a frame lasts at least `SCK_HALF` system cycles. With the defaults (`SCK_HALF`=5 at 100 MHz) the clock therefore stays at or below 10 MHz.
- R4: Chip-select stays low for the whole of a frame, which is one opcode followed by all of its parameters. It stays high for at least `2*SCK_HALF` cycles between frames. The opcode byte is sent with `spi_dc_o`=0 and every parameter byte with `spi_dc_o`=1.
- R5: The start-up frames go out in this order, each shown as opcode and parameter count: CF/3, ED/4, E8/3, CB/5, F7/1, C0/1, C1/1, C5/2, 36/1, 2A/4, 2B/4, 3A/1, 2C/0, 26/1, E0/15, E1/15, 11/0, 29/0, 2C/0.
- R6: The parameters of 0x2A are 0x00, 0x00, then the high and low byte of `H_PIXELS-1`. The parameters of 0x2B are 0x00, 0x00, then the high and low byte of `V_LINES-1`. The single parameter of 0x3A is 0x55.
- R7: At least `LONG_MS*CLK_PER_MS` cycles pass between the end of the first 0x2C frame and the start of the 0x26 frame. The same minimum applies between the end of the 0x11 frame and the start of the 0x29 frame.
- R8: `busy_o` is high from the cycle after an accepted request until the last frame has ended. `done_o` is then high for exactly one cycle, and `busy_o` is low in that cycle.
- R9: When the panel is running, an `enable_i` pulse sends a single 0x29 frame and a `disable_i` pulse sends a single 0x28 frame. Neither frame has parameters, and each is followed by a `done_o` pulse.
- R10: `enable_i` and `disable_i` have no effect while powered off or busy, and `start_i` has no effect while running. No frame is sent and the supply and reset pins keep their levels.
- R11: A `stop_i` pulse when the panel is running drives `panel_rst_n_o` low, and `supply_en_o` falls exactly one cycle later. A later `start_i` repeats the whole start-up sequence.
- R12: When requests arrive in the same cycle, `stop_i` wins over `disable_i`, and `disable_i` wins over `enable_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| start_i | input | 1 | Power-up and initialise request (taken when powered off) |
| stop_i | input | 1 | Power-down request (taken when running) |
| enable_i | input | 1 | Send display-on request (taken when running) |
| disable_i | input | 1 | Send display-off request (taken when running) |
| supply_en_o | output | 1 | Panel supply enable |
| panel_rst_n_o | output | 1 | Panel reset, active low |
| spi_cs_n_o | output | 1 | Serial chip-select, active low |
| spi_sck_o | output | 1 | Serial clock, mode 0 |
| spi_mosi_o | output | 1 | Serial data to panel, MSB first |
| spi_dc_o | output | 1 | 0 for opcode byte, 1 for parameter byte |
| busy_o | output | 1 | A sequence or single command is in progress |
| done_o | output | 1 | One-cycle pulse when a sequence or single command ends |

## Verification
The assertions assume that the request pins are synchronous to `clk` and are only sampled in the powered-off or running states. They also assume that the timer is never restarted while it is counting, and that `SCK_HALF` and `CLK_PER_MS` are at least one. The stimulus changes the request pins only on falling clock edges, as one-cycle pulses. It waits for `done_o` before it issues the next accepted request, and it sends requests that must be ignored both before power-up and in the middle of the start-up sequence. A reduced `CLK_PER_MS` keeps the 20 ms and 200 ms waits short. The bench still checks them against the same cycle counts that the parameters define.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  typedef struct packed {
    logic [7:0] op;
    logic [4:0] cnt;
    logic       pause;
  } cmd_t;

  localparam int          NCMD       = 19;
  localparam int          IDXW       = 5;
  localparam logic [7:0]  OP_DISP_ON  = 8'h29;
  localparam logic [7:0]  OP_DISP_OFF = 8'h28;

  // start-up table: opcode, parameter count, long pause after the frame
  function automatic cmd_t cmd_at(input logic [IDXW-1:0] i);
    cmd_t c;
    case (i)
      5'd0:    c = '{8'hCF, 5'd3,  1'b0};
      5'd1:    c = '{8'hED, 5'd4,  1'b0};
      5'd2:    c = '{8'hE8, 5'd3,  1'b0};
      5'd3:    c = '{8'hCB, 5'd5,  1'b0};
      5'd4:    c = '{8'hF7, 5'd1,  1'b0};
      5'd5:    c = '{8'hC0, 5'd1,  1'b0};
      5'd6:    c = '{8'hC1, 5'd1,  1'b0};
      5'd7:    c = '{8'hC5, 5'd2,  1'b0};
      5'd8:    c = '{8'h36, 5'd1,  1'b0};
      5'd9:    c = '{8'h2A, 5'd4,  1'b0};
      5'd10:   c = '{8'h2B, 5'd4,  1'b0};
      5'd11:   c = '{8'h3A, 5'd1,  1'b0};
      5'd12:   c = '{8'h2C, 5'd0,  1'b1};
      5'd13:   c = '{8'h26, 5'd1,  1'b0};
      5'd14:   c = '{8'hE0, 5'd15, 1'b0};
      5'd15:   c = '{8'hE1, 5'd15, 1'b0};
      5'd16:   c = '{8'h11, 5'd0,  1'b1};
      5'd17:   c = '{8'h29, 5'd0,  1'b0};
      5'd18:   c = '{8'h2C, 5'd0,  1'b0};
      default: c = '{8'h00, 5'd0,  1'b0};
    endcase
    return c;
  endfunction

  // parameter byte k of a command, computed rather than stored
  function automatic logic [7:0] par_at(input logic [7:0] op, input logic [4:0] k,
                                        input logic [15:0] colmax, input logic [15:0] rowmax);
    logic [7:0] b;
    case (op)
      8'h2A:   b = (k == 5'd2) ? colmax[15:8] : (k == 5'd3) ? colmax[7:0] : 8'h00;
      8'h2B:   b = (k == 5'd2) ? rowmax[15:8] : (k == 5'd3) ? rowmax[7:0] : 8'h00;
      8'h3A:   b = 8'h55;
      8'h36:   b = 8'h48;
      8'h26:   b = 8'h01;
      8'hF7:   b = 8'h20;
      8'hE0:   b = {k, 3'b010};
      8'hE1:   b = 8'h78 - {1'b0, k, 2'b00};
      default: b = {3'b100, k};
    endcase
    return b;
  endfunction

endpackage

// File: rtl/bsq_ms_timer.sv
module bsq_ms_timer #(
  parameter int CLK_PER_MS = 100000,
  parameter int MSW        = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go_i,
  input  logic [MSW-1:0] ms_i,
  output logic           done_o
);
  localparam int             CW     = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [CW-1:0]  CYC_M1 = CW'(CLK_PER_MS - 1);

  logic           run;
  logic [MSW-1:0] ms_left;
  logic [CW-1:0]  cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      ms_left <= '0;
      cyc     <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        run     <= 1'b1;
        ms_left <= ms_i;
        cyc     <= CYC_M1;
      end else if (run) begin
        if (cyc == '0) begin
          if (ms_left <= MSW'(1)) begin
            run    <= 1'b0;
            done_o <= 1'b1;
          end else begin
            ms_left <= ms_left - MSW'(1);
            cyc     <= CYC_M1;
          end
        end else begin
          cyc <= cyc - CW'(1);
        end
      end
    end
  end

  p_done_after_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(run));
  p_go_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !run);

endmodule

// File: rtl/bsq_spi_tx.sv
module bsq_spi_tx #(
  parameter int SCK_HALF = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_dc,
  input  logic       in_last,
  output logic       idle_o,
  output logic       cs_n_o,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       dc_o
);
  localparam int             HCW     = $clog2(2 * SCK_HALF);
  localparam logic [HCW-1:0] HALF_M1 = HCW'(SCK_HALF - 1);
  localparam logic [HCW-1:0] GAP_M1  = HCW'(2 * SCK_HALF - 1);

  typedef enum logic [2:0] {PH_IDLE, PH_LOW, PH_HIGH, PH_HOLD, PH_GAP} ph_t;

  ph_t            ph;
  logic [7:0]     sh;
  logic [2:0]     bits;
  logic           last_q;
  logic [HCW-1:0] hc;

  assign in_ready = (ph == PH_IDLE) || (ph == PH_HOLD);
  assign idle_o   = (ph == PH_IDLE);
  assign mosi_o   = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cs_n_o <= 1'b1;
      sck_o  <= 1'b0;
      sh     <= '0;
      bits   <= '0;
      dc_o   <= 1'b0;
      last_q <= 1'b0;
      hc     <= '0;
    end else begin
      case (ph)
        PH_IDLE, PH_HOLD: if (in_valid) begin
          cs_n_o <= 1'b0;
          sh     <= in_data;
          dc_o   <= in_dc;
          last_q <= in_last;
          bits   <= 3'd7;
          hc     <= HALF_M1;
          ph     <= PH_LOW;
        end
        PH_LOW: if (hc == '0) begin
          sck_o <= 1'b1;
          hc    <= HALF_M1;
          ph    <= PH_HIGH;
        end else hc <= hc - HCW'(1);
        PH_HIGH: if (hc == '0) begin
          sck_o <= 1'b0;
          hc    <= HALF_M1;
          if (bits == 3'd0) begin
            if (last_q) begin
              cs_n_o <= 1'b1;
              hc     <= GAP_M1;
              ph     <= PH_GAP;
            end else ph <= PH_HOLD;
          end else begin
            sh   <= {sh[6:0], 1'b0};
            bits <= bits - 3'd1;
            ph   <= PH_LOW;
          end
        end else hc <= hc - HCW'(1);
        PH_GAP: if (hc == '0) ph <= PH_IDLE;
                else hc <= hc - HCW'(1);
        default: ph <= PH_IDLE;
      endcase
    end
  end

  p_sck_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> !cs_n_o);
  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));
  p_dc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sck_o |-> $stable(dc_o));

endmodule

// File: rtl/panel_bringup_seq.sv
module panel_bringup_seq
  import bsq_pkg::*;
#(
  parameter int CLK_PER_MS = 100000,
  parameter int SCK_HALF   = 5,
  parameter int RST_MS     = 20,
  parameter int LONG_MS    = 200,
  parameter int H_PIXELS   = 240,
  parameter int V_LINES    = 320
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic enable_i,
  input  logic disable_i,
  output logic supply_en_o,
  output logic panel_rst_n_o,
  output logic spi_cs_n_o,
  output logic spi_sck_o,
  output logic spi_mosi_o,
  output logic spi_dc_o,
  output logic busy_o,
  output logic done_o
);
  localparam int               MSW     = 8;
  localparam logic [15:0]      COL_MAX = 16'(H_PIXELS - 1);
  localparam logic [15:0]      ROW_MAX = 16'(V_LINES - 1);
  localparam logic [IDXW-1:0]  LAST_IX = IDXW'(NCMD - 1);

  typedef enum logic [3:0] {
    ST_OFF, ST_PWR, ST_RST, ST_OP, ST_PAR, ST_FRM, ST_LONG, ST_ON, ST_DOWN
  } st_t;

  st_t             state;
  logic [IDXW-1:0] idx;
  logic [4:0]      pidx;
  logic            single_q;
  logic [7:0]      single_op;
  cmd_t            cur;
  logic            at_end;

  logic            tx_valid, tx_ready, tx_dc, tx_last, tx_idle, tx_fire;
  logic [7:0]      tx_data;
  logic            tmr_go, tmr_done;
  logic [MSW-1:0]  tmr_ms;

  assign cur     = cmd_at(idx);
  assign at_end  = (idx == LAST_IX);
  assign tx_fire = tx_valid && tx_ready;
  assign busy_o  = (state != ST_OFF) && (state != ST_ON);

  always_comb begin
    tx_valid = (state == ST_OP) || (state == ST_PAR);
    tx_dc    = (state == ST_PAR);
    if (state == ST_OP) begin
      tx_data = single_q ? single_op : cur.op;
      tx_last = single_q || (cur.cnt == 5'd0);
    end else begin
      tx_data = par_at(cur.op, pidx, COL_MAX, ROW_MAX);
      tx_last = (pidx == cur.cnt - 5'd1);
    end
  end

  always_comb begin
    tmr_go = 1'b0;
    tmr_ms = MSW'(RST_MS);
    case (state)
      ST_OFF:  tmr_go = start_i;
      ST_PWR:  tmr_go = tmr_done;
      ST_FRM:  if (tx_idle && !single_q && cur.pause) begin
        tmr_go = 1'b1;
        tmr_ms = MSW'(LONG_MS);
      end
      default: tmr_go = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_OFF;
      supply_en_o   <= 1'b0;
      panel_rst_n_o <= 1'b0;
      idx           <= '0;
      pidx          <= '0;
      single_q      <= 1'b0;
      single_op     <= '0;
      done_o        <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_OFF: if (start_i) begin
          supply_en_o <= 1'b1;
          state       <= ST_PWR;
        end
        ST_PWR: if (tmr_done) begin
          panel_rst_n_o <= 1'b1;
          state         <= ST_RST;
        end
        ST_RST: if (tmr_done) begin
          idx      <= '0;
          single_q <= 1'b0;
          state    <= ST_OP;
        end
        ST_OP: if (tx_fire) begin
          pidx  <= '0;
          state <= tx_last ? ST_FRM : ST_PAR;
        end
        ST_PAR: if (tx_fire) begin
          if (tx_last) state <= ST_FRM;
          else         pidx  <= pidx + 5'd1;
        end
        ST_FRM: if (tx_idle) begin
          if (single_q || (at_end && !cur.pause)) begin
            state  <= ST_ON;
            done_o <= 1'b1;
          end else if (cur.pause) begin
            state <= ST_LONG;
          end else begin
            idx   <= idx + IDXW'(1);
            state <= ST_OP;
          end
        end
        ST_LONG: if (tmr_done) begin
          if (at_end) begin
            state  <= ST_ON;
            done_o <= 1'b1;
          end else begin
            idx   <= idx + IDXW'(1);
            state <= ST_OP;
          end
        end
        ST_ON: begin
          if (stop_i) begin
            panel_rst_n_o <= 1'b0;
            state         <= ST_DOWN;
          end else if (disable_i) begin
            single_q  <= 1'b1;
            single_op <= OP_DISP_OFF;
            state     <= ST_OP;
          end else if (enable_i) begin
            single_q  <= 1'b1;
            single_op <= OP_DISP_ON;
            state     <= ST_OP;
          end
        end
        ST_DOWN: begin
          supply_en_o <= 1'b0;
          state       <= ST_OFF;
        end
        default: state <= ST_OFF;
      endcase
    end
  end

  bsq_ms_timer #(.CLK_PER_MS(CLK_PER_MS), .MSW(MSW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (tmr_go),
    .ms_i   (tmr_ms),
    .done_o (tmr_done)
  );

  bsq_spi_tx #(.SCK_HALF(SCK_HALF)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (tx_valid),
    .in_ready (tx_ready),
    .in_data  (tx_data),
    .in_dc    (tx_dc),
    .in_last  (tx_last),
    .idle_o   (tx_idle),
    .cs_n_o   (spi_cs_n_o),
    .sck_o    (spi_sck_o),
    .mosi_o   (spi_mosi_o),
    .dc_o     (spi_dc_o)
  );

  p_frame_powered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n_o |-> (panel_rst_n_o && supply_en_o));
  p_opcode_dc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n_o) |-> !spi_dc_o);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && spi_cs_n_o));
  p_reset_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(supply_en_o) |-> (!panel_rst_n_o && $past(!panel_rst_n_o)));

endmodule

// File: tb/test_panel_bringup_seq.sv
module test_panel_bringup_seq;
  localparam int CPM = 4;
  localparam int SH  = 2;
  localparam int RMS = 20;
  localparam int LMS = 200;
  localparam int HP  = 240;
  localparam int VL  = 320;

  typedef struct {
    logic [7:0] val;
    logic       dc;
    bit         chk;
    bit         first;
    bit         last;
    int         min_gap;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, stop_i = 0, enable_i = 0, disable_i = 0;
  logic supply_en_o, panel_rst_n_o, spi_cs_n_o, spi_sck_o, spi_mosi_o, spi_dc_o, busy_o, done_o;

  int checks = 0, errors = 0, cyc = 0, nbytes = 0;
  item_t exp_q[$];

  logic [7:0] ops  [19] = '{8'hCF, 8'hED, 8'hE8, 8'hCB, 8'hF7, 8'hC0, 8'hC1, 8'hC5, 8'h36, 8'h2A,
                            8'h2B, 8'h3A, 8'h2C, 8'h26, 8'hE0, 8'hE1, 8'h11, 8'h29, 8'h2C};
  int         cnts [19] = '{3, 4, 3, 5, 1, 1, 1, 2, 1, 4, 4, 1, 0, 1, 15, 15, 0, 0, 0};

  always #5 clk = ~clk;

  panel_bringup_seq #(.CLK_PER_MS(CPM), .SCK_HALF(SH), .RST_MS(RMS), .LONG_MS(LMS),
                      .H_PIXELS(HP), .V_LINES(VL)) i_panel_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .enable_i(enable_i), .disable_i(disable_i), .supply_en_o(supply_en_o),
    .panel_rst_n_o(panel_rst_n_o), .spi_cs_n_o(spi_cs_n_o), .spi_sck_o(spi_sck_o),
    .spi_mosi_o(spi_mosi_o), .spi_dc_o(spi_dc_o), .busy_o(busy_o), .done_o(done_o));

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  function automatic logic [7:0] exp_par(input logic [7:0] op, input int k, output bit chk);
    logic [15:0] c = 16'(HP - 1);
    logic [15:0] r = 16'(VL - 1);
    chk = 1'b1;
    if (op == 8'h2A)      return (k == 2) ? c[15:8] : (k == 3) ? c[7:0] : 8'h00;
    else if (op == 8'h2B) return (k == 2) ? r[15:8] : (k == 3) ? r[7:0] : 8'h00;
    else if (op == 8'h3A) return 8'h55;
    chk = 1'b0;
    return 8'h00;
  endfunction

  // driver side of the scoreboard: one frame of expected bytes
  task automatic push_frame(input logic [7:0] op, input int cnt, input int gap, input string gtag);
    item_t it;
    it = '{val: op, dc: 1'b0, chk: 1'b1, first: 1'b1, last: (cnt == 0), min_gap: gap, tag: gtag};
    exp_q.push_back(it);
    for (int k = 0; k < cnt; k++) begin
      bit c;
      logic [7:0] v;
      v = exp_par(op, k, c);
      it = '{val: v, dc: 1'b1, chk: c, first: 1'b0, last: (k == cnt - 1), min_gap: 0, tag: "R6"};
      exp_q.push_back(it);
    end
  endtask

  task automatic push_init();
    for (int i = 0; i < 19; i++) begin
      if (i == 0)                 push_frame(ops[i], cnts[i], RMS * CPM, "R2");
      else if (i == 13 || i == 17) push_frame(ops[i], cnts[i], LMS * CPM, "R7");
      else                        push_frame(ops[i], cnts[i], 2 * SH, "R4");
    end
  endtask

  task automatic pulse(input bit s, input bit p, input bit e, input bit d);
    @(negedge clk);
    start_i = s; stop_i = p; enable_i = e; disable_i = d;
    @(negedge clk);
    start_i = 0; stop_i = 0; enable_i = 0; disable_i = 0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done_o && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(done_o == 1'b1, req, "done pulse seen", done_o, 1);
    check(busy_o == 1'b0, "R8", "busy low with done", busy_o, 0);
    @(negedge clk);
    check(done_o == 1'b0, "R8", "done width one cycle", done_o, 0);
  endtask

  // monitor: decodes the serial link and pops the scoreboard
  logic p_sup, p_prst, p_cs, p_sck, p_mosi;
  logic [7:0] shreg;
  int nbit, byte_ix, ph_len, last_rise, pend_gap, t_sup, t_rfall;
  bit last_was_last;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      p_sup = 0; p_prst = 0; p_cs = 1; p_sck = 0; p_mosi = 0;
      nbit = 0; byte_ix = 0; ph_len = 0; last_rise = 0; pend_gap = 0;
      t_sup = 0; t_rfall = 0; last_was_last = 1;
    end else begin
      if (supply_en_o && !p_sup) t_sup = cyc;
      if (panel_rst_n_o && !p_prst) begin
        check((cyc - t_sup) >= RMS * CPM && (cyc - t_sup) <= RMS * CPM + 2, "R2",
              "reset release delay", cyc - t_sup, RMS * CPM + 1);
        last_rise = cyc;
      end
      if (!panel_rst_n_o && p_prst) t_rfall = cyc;
      if (!supply_en_o && p_sup)
        check((cyc - t_rfall) == 1, "R11", "supply off after reset", cyc - t_rfall, 1);
      if (spi_sck_o != p_sck) begin
        if (!spi_cs_n_o && ph_len < SH)
          check(1'b0, "R3", "sck phase length", ph_len, SH);
        ph_len = 1;
      end else ph_len++;
      if (spi_sck_o && p_sck && spi_mosi_o != p_mosi)
        check(1'b0, "R3", "mosi changed while sck high", spi_mosi_o, p_mosi);
      if (!spi_cs_n_o && p_cs) begin
        nbit = 0; byte_ix = 0; pend_gap = cyc - last_rise;
      end
      if (spi_sck_o && !p_sck && !spi_cs_n_o) begin
        shreg = {shreg[6:0], spi_mosi_o};
        nbit++;
        if (nbit == 8) begin
          nbytes++;
          if (exp_q.size() == 0) begin
            check(1'b0, "R10", "unexpected byte", shreg, 0);
          end else begin
            item_t it;
            it = exp_q.pop_front();
            check(spi_dc_o == it.dc, "R4", "dc level", spi_dc_o, it.dc);
            check(((byte_ix == 0) == it.first), "R4", "frame start position", byte_ix, it.first ? 0 : 1);
            if (it.chk) check(shreg == it.val, it.first ? "R5" : "R6", "byte value", shreg, it.val);
            if (it.first) check(pend_gap >= it.min_gap, it.tag, "gap before frame", pend_gap, it.min_gap);
            last_was_last = it.last;
          end
          nbit = 0;
          byte_ix++;
        end
      end
      if (spi_cs_n_o && !p_cs) begin
        check(last_was_last, "R4", "cs rise at frame end", byte_ix, 0);
        last_rise = cyc;
      end
      p_sup = supply_en_o; p_prst = panel_rst_n_o; p_cs = spi_cs_n_o;
      p_sck = spi_sck_o; p_mosi = spi_mosi_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R8", "watchdog expired", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int nb;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(supply_en_o == 0, "R1", "supply off", supply_en_o, 0);
    check(panel_rst_n_o == 0, "R1", "panel reset held", panel_rst_n_o, 0);
    check(spi_cs_n_o == 1, "R1", "cs idle", spi_cs_n_o, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(spi_sck_o == 0, "R1", "sck idle", spi_sck_o, 0);
    check(busy_o == 0 && done_o == 0, "R1", "busy/done low", {busy_o, done_o}, 0);

    // R10: display requests while powered off are ignored
    pulse(0, 0, 1, 1);
    repeat (40) @(negedge clk);
    check(spi_cs_n_o == 1 && nbytes == 0, "R10", "no frame while off", nbytes, 0);
    check(supply_en_o == 0 && busy_o == 0, "R10", "still off", supply_en_o, 0);

    // R2 R5 R6 R7: full start-up
    push_init();
    pulse(1, 0, 0, 0);
    check(busy_o == 1, "R8", "busy after start", busy_o, 1);
    check(supply_en_o == 1 && panel_rst_n_o == 0, "R2", "supply on, reset held",
          {supply_en_o, panel_rst_n_o}, 2);
    repeat (300) @(negedge clk);
    pulse(0, 0, 1, 1);  // R10: ignored mid-sequence
    wait_done("R8");
    check(exp_q.size() == 0, "R5", "all start-up bytes seen", exp_q.size(), 0);

    // R10: start while running is ignored
    nb = nbytes;
    pulse(1, 0, 0, 0);
    repeat (60) @(negedge clk);
    check(nbytes == nb && busy_o == 0, "R10", "start ignored when running", nbytes - nb, 0);

    // R9: single display-on and display-off
    push_frame(8'h29, 0, 2 * SH, "R9");
    pulse(0, 0, 1, 0);
    wait_done("R9");
    check(exp_q.size() == 0, "R9", "display-on frame", exp_q.size(), 0);
    push_frame(8'h28, 0, 2 * SH, "R9");
    pulse(0, 0, 0, 1);
    wait_done("R9");
    check(exp_q.size() == 0, "R9", "display-off frame", exp_q.size(), 0);

    // R12: disable wins over enable
    push_frame(8'h28, 0, 2 * SH, "R12");
    pulse(0, 0, 1, 1);
    wait_done("R12");
    check(exp_q.size() == 0, "R12", "disable chosen", exp_q.size(), 0);

    // R12 R11: stop wins over disable, then power down
    nb = nbytes;
    pulse(0, 1, 0, 1);
    repeat (20) @(negedge clk);
    check(nbytes == nb, "R12", "no frame on stop", nbytes - nb, 0);
    check(supply_en_o == 0 && panel_rst_n_o == 0 && busy_o == 0, "R11", "powered down",
          {supply_en_o, panel_rst_n_o, busy_o}, 0);

    // R11: restart runs the whole sequence again
    push_init();
    pulse(1, 0, 0, 0);
    wait_done("R11");
    check(exp_q.size() == 0, "R11", "second start-up complete", exp_q.size(), 0);

    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule